// File: doc/BRIEF.md
# Differencing Two-Stage Multiuser Interference Canceller

This block removes multiple-access interference from the matched-filter outputs of up to eight binary antipodal (BPSK) users. It first takes a hard decision per user from the sign of its matched-filter sample. It then runs exactly two cancellation stages. In each stage, every user's soft statistic is corrected by the cross-correlation with the other users, weighted by how much their decisions moved since the previous stage.

In the second stage a decision can only stay put or flip, so each weight is 0 or ±2. Unchanged users cost nothing: the walker jumps over them without spending a cycle. A flipped user's coefficient is doubled by a one-bit left shift and then added or subtracted; no multiplier exists. In the first stage the reference vector is all zeros, so each weight is the stage-0 decision (±1) and the coefficient enters unshifted.

Software-side logic loads the samples and the correlation matrix through two sequential write strobes while the block is idle. It sets the active user count and pulses `start`. The final decisions appear on `bits_out` together with a one-cycle `done` pulse. The run always has two stages, so its length depends only on the count of changed decisions and never on convergence.

Top module: `mai_canceller`

## Requirements
- R1: While idle, each `mf_valid` cycle stores `mf_data` as the sample of the user at the sample pointer and advances it (user 0 first). Each `coef_valid` cycle stores `coef_data` as R[row][col] at the coefficient pointer, row-major with index row*8+col, and advances it. Both pointers return to 0 on reset and when a start is accepted. Strobes and `start` seen while `busy` is high change nothing.
- R2: The stage-0 decision of user k is +1 when its sample is zero or positive and −1 when it is negative.
- R3: Each of the two stages computes, for every active user k, z_new[k] = z_old[k] − Σ over active j≠k of R[k][j]·(d_prev[j] − d_prevprev[j]). The new decision is +1 when z_new[k] ≥ 0, else −1. z starts as the samples. For the first stage, d_prevprev is all zeros.
- R4: The diagonal coefficient R[k][k] never enters user k's update, whatever it holds.
- R5: Each updated soft statistic is clamped to the signed 12-bit range [−2048, 2047] when written back. The next stage starts from the clamped value. The wide accumulator never wraps.
- R6: A stage with nonzero differences takes 2 cycles plus, for each active user, one cycle per other active user whose difference is nonzero plus one write-back cycle. The count of edges from the one that samples `start` up to the one that raises `done` is 3 plus the cost of the two stages.
- R7: A stage in which no active user's decision differs from the stage before takes exactly one cycle and leaves all decisions unchanged.
- R8: A `num_users` value above 8 acts as 8. Users at index ≥ the count take no part in any update. On `bits_out`, bit k is 1 for +1 and 0 for −1, and bits at or above the count read 0.
- R9: After reset `busy`, `done` and `bits_out` are 0. `busy` rises the cycle after a start is accepted. `done` is a single-cycle pulse, with `busy` low, when both stages are over. `bits_out` holds its value until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| num_users | input | 4 | Active user count, sampled with `start` |
| mf_valid | input | 1 | Sample write strobe |
| mf_data | input | 12 | Signed matched-filter sample |
| coef_valid | input | 1 | Correlation coefficient write strobe |
| coef_data | input | 12 | Signed correlation coefficient |
| start | input | 1 | Begin detection when idle |
| busy | output | 1 | Detection in progress |
| done | output | 1 | One-cycle completion pulse |
| bits_out | output | 8 | Final decisions, 1 = +1 |

## Verification
A four-user sweep crosses every combination of four sample levels (negative, tiny negative, zero, positive) against a fixed asymmetric matrix. This exercises zero-to-plus mapping and both flip directions in the second stage, and shows whether the bypass count matches the latency formula. Pseudo-random loads over every count from 0 to 10 separate correct clamping of the count and masking of idle users from leakage across the boundary. Directed cases follow. One pushes a statistic into saturation, where only a correctly clamped value yields the right second-stage flip. One uses a zero matrix, where the second stage must collapse to one cycle. A nonzero diagonal must be ignored. A run is flooded with strobes and `start`, and a later rerun without reloading must reproduce the first result.

// File: rtl/mud_pkg.sv
// Shared definitions for the differencing interference canceller.
// Assumes a two-stage schedule; the phase type covers one whole run.
package mud_pkg;

    // Phases of one detection run
    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for start
        PH_SEED,   // stage-0 decisions from samples
        PH_OPEN,   // stage entry: skip test and first-user load
        PH_WORK,   // term accumulation and write-back per user
        PH_CLOSE,  // rotate decision vectors at stage end
        PH_DONE    // publish decisions and pulse done
    } phase_e;

endpackage

// File: rtl/mud_store.sv
// Holds the matched-filter samples and the correlation matrix.
// Both are filled by sequential strobes with auto-advancing pointers;
// writes are accepted only while wr_en is high, and restart clears
// both pointers. The matrix has one combinational read port.
module mud_store #(
    parameter int MAXU = 8,
    parameter int DW   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       restart,
    input  logic                       mf_valid,
    input  logic [DW-1:0]              mf_data,
    input  logic                       coef_valid,
    input  logic [DW-1:0]              coef_data,
    input  logic [$clog2(MAXU)-1:0]    rd_row,
    input  logic [$clog2(MAXU)-1:0]    rd_col,
    output logic [DW-1:0]              coef_rd,
    output logic [MAXU-1:0][DW-1:0]    mf_all,
    output logic [$clog2(MAXU)-1:0]    mf_ptr,
    output logic [$clog2(MAXU*MAXU)-1:0] coef_ptr
);
    localparam int SW    = $clog2(MAXU);
    localparam int NCOEF = MAXU * MAXU;
    localparam int CW    = $clog2(NCOEF);

    logic [NCOEF-1:0][DW-1:0] coef_q;
    logic [CW-1:0]            rd_idx;

    // Sample pointer: advance per accepted sample, wrap after the last user
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            mf_ptr <= '0;
        end else if (wr_en && mf_valid) begin
            mf_ptr <= (mf_ptr == SW'(MAXU - 1)) ? '0 : mf_ptr + 1'b1;
        end
    end

    // Coefficient pointer: row-major walk over the whole matrix
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            coef_ptr <= '0;
        end else if (wr_en && coef_valid) begin
            coef_ptr <= (coef_ptr == CW'(NCOEF - 1)) ? '0 : coef_ptr + 1'b1;
        end
    end

    // One register per user sample
    for (genvar g = 0; g < MAXU; g++) begin : g_sample
        // Capture the sample addressed by the pointer
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mf_all[g] <= '0;
            end else if (wr_en && mf_valid && mf_ptr == SW'(g)) begin
                mf_all[g] <= mf_data;
            end
        end
    end

    // Matrix storage written at the coefficient pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCOEF; i++) coef_q[i] <= '0;
        end else if (wr_en && coef_valid) begin
            coef_q[coef_ptr] <= coef_data;
        end
    end

    assign rd_idx  = CW'(rd_row) * CW'(MAXU) + CW'(rd_col);
    assign coef_rd = coef_q[rd_idx];

endmodule

// File: rtl/mud_term.sv
// Picks the next contributing user from a pending mask (lowest index
// first) and forms its signed addend. The addend is the coefficient,
// shifted left by one when dbl is set, negated when the selected user's
// current decision is +1 (positive difference). No multiplier is used.
module mud_term #(
    parameter int MAXU = 8,
    parameter int DW   = 12,
    parameter int AW   = 17
) (
    input  logic [MAXU-1:0]              pend,
    input  logic [MAXU-1:0]              dec_cur,
    input  logic [DW-1:0]                coef,
    input  logic                         dbl,
    output logic                         any,
    output logic [$clog2(MAXU)-1:0]      sel,
    output logic signed [AW-1:0]         addend
);
    localparam int SW = $clog2(MAXU);

    logic signed [AW-1:0] ext;
    logic signed [AW-1:0] scaled;

    // Priority pick: lowest set bit of the pending mask
    always_comb begin
        sel = '0;
        for (int i = MAXU - 1; i >= 0; i--) begin
            if (pend[i]) sel = SW'(i);
        end
    end

    assign any    = |pend;
    assign ext    = {{(AW-DW){coef[DW-1]}}, coef};
    assign scaled = dbl ? (ext <<< 1) : ext;
    assign addend = dec_cur[sel] ? -scaled : scaled;

endmodule

// File: rtl/mud_ctrl.sv
// Sequencer and datapath of the canceller. Seeds decisions from the
// samples, then runs two stages. Each stage walks the active users in
// order; per user it accumulates one addend per pending contributor and
// then writes back the clamped statistic and its decision into a
// separate next-decision vector, so all users in a stage see the same
// previous decisions. A stage with no changed decisions is skipped.
module mud_ctrl #(
    parameter int MAXU = 8,
    parameter int DW   = 12,
    parameter int AW   = 17
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [$clog2(MAXU+1)-1:0]      num_users,
    input  logic [MAXU-1:0][DW-1:0]        mf_all,
    input  logic                           term_any,
    input  logic [$clog2(MAXU)-1:0]        term_sel,
    input  logic signed [AW-1:0]           addend,
    output logic                           busy,
    output logic                           done,
    output logic [MAXU-1:0]                bits_out,
    output logic                           accept,
    output logic [$clog2(MAXU)-1:0]        row_k,
    output logic [MAXU-1:0]                pend,
    output logic [MAXU-1:0]                dec_cur,
    output logic                           dbl,
    output logic [MAXU-1:0]                act_mask
);
    import mud_pkg::*;

    localparam int SW = $clog2(MAXU);
    localparam int NW = $clog2(MAXU + 1);

    phase_e                  ph_q;
    logic [NW-1:0]           n_q;
    logic                    stage_q;
    logic [SW-1:0]           k_q;
    logic [SW-1:0]           k_nx;
    logic signed [AW-1:0]    acc_q;
    logic [MAXU-1:0][DW-1:0] z_q;
    logic [MAXU-1:0]         dec_old;
    logic [MAXU-1:0]         dec_nxt;
    logic [MAXU-1:0]         changed;
    logic [MAXU-1:0]         base;
    logic [DW-1:0]           wb;
    logic                    last_user;
    logic                    done_q;
    logic [MAXU-1:0]         bits_q;

    // Clamp a wide accumulator value to the signed statistic range
    function automatic logic [DW-1:0] clamp(input logic signed [AW-1:0] a);
        if ((&a[AW-1:DW-1]) || !(|a[AW-1:DW-1])) begin
            return a[DW-1:0];
        end else if (a[AW-1]) begin
            return {1'b1, {(DW-1){1'b0}}};
        end else begin
            return {1'b0, {(DW-1){1'b1}}};
        end
    endfunction

    // Sign-extend a stored statistic into the accumulator width
    function automatic logic signed [AW-1:0] widen(input logic [DW-1:0] v);
        return {{(AW-DW){v[DW-1]}}, v};
    endfunction

    // Active-user mask from the latched count
    for (genvar g = 0; g < MAXU; g++) begin : g_act
        assign act_mask[g] = (NW'(g) < n_q);
    end

    assign changed   = stage_q ? (dec_cur ^ dec_old) : '1;
    assign base      = changed & act_mask;
    assign wb        = clamp(acc_q);
    assign k_nx      = k_q + 1'b1;
    assign last_user = ((NW'(k_q) + 1'b1) == n_q);

    assign busy     = (ph_q != PH_IDLE);
    assign accept   = (ph_q == PH_IDLE) && start;
    assign done     = done_q;
    assign bits_out = bits_q;
    assign row_k    = k_q;
    assign dbl      = stage_q;

    // Run sequencer, accumulator and decision bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            n_q     <= '0;
            stage_q <= 1'b0;
            k_q     <= '0;
            acc_q   <= '0;
            pend    <= '0;
            dec_cur <= '0;
            dec_old <= '0;
            dec_nxt <= '0;
            done_q  <= 1'b0;
            bits_q  <= '0;
            for (int i = 0; i < MAXU; i++) z_q[i] <= '0;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        n_q  <= (num_users > NW'(MAXU)) ? NW'(MAXU) : num_users;
                        ph_q <= PH_SEED;
                    end
                end
                PH_SEED: begin
                    for (int i = 0; i < MAXU; i++) begin
                        z_q[i]     <= mf_all[i];
                        dec_cur[i] <= ~mf_all[i][DW-1];
                    end
                    dec_old <= '0;
                    stage_q <= 1'b0;
                    ph_q    <= PH_OPEN;
                end
                PH_OPEN: begin
                    if (base == '0) begin
                        dec_old <= dec_cur;
                        stage_q <= 1'b1;
                        ph_q    <= stage_q ? PH_DONE : PH_OPEN;
                    end else begin
                        k_q     <= '0;
                        acc_q   <= widen(z_q[0]);
                        pend    <= base & ~MAXU'(1);
                        dec_nxt <= dec_cur;
                        ph_q    <= PH_WORK;
                    end
                end
                PH_WORK: begin
                    if (term_any) begin
                        acc_q          <= acc_q + addend;
                        pend[term_sel] <= 1'b0;
                    end else begin
                        z_q[k_q]     <= wb;
                        dec_nxt[k_q] <= ~wb[DW-1];
                        if (last_user) begin
                            ph_q <= PH_CLOSE;
                        end else begin
                            k_q   <= k_nx;
                            acc_q <= widen(z_q[k_nx]);
                            pend  <= base & ~(MAXU'(1) << k_nx);
                        end
                    end
                end
                PH_CLOSE: begin
                    dec_old <= dec_cur;
                    dec_cur <= dec_nxt;
                    stage_q <= 1'b1;
                    ph_q    <= stage_q ? PH_DONE : PH_OPEN;
                end
                PH_DONE: begin
                    bits_q <= dec_cur & act_mask;
                    done_q <= 1'b1;
                    ph_q   <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mai_canceller.sv
// Top of the differencing two-stage interference canceller. Connects
// the sample/matrix store, the term selector and the sequencer. The
// matrix read row is the user being updated, the column the selected
// contributor.
module mai_canceller #(
    parameter int MAXU = 8,
    parameter int DW   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(MAXU+1)-1:0]   num_users,
    input  logic                        mf_valid,
    input  logic [DW-1:0]               mf_data,
    input  logic                        coef_valid,
    input  logic [DW-1:0]               coef_data,
    input  logic                        start,
    output logic                        busy,
    output logic                        done,
    output logic [MAXU-1:0]             bits_out
);
    localparam int SW = $clog2(MAXU);
    localparam int CW = $clog2(MAXU * MAXU);
    localparam int AW = DW + SW + 2;

    logic                     accept;
    logic [SW-1:0]            row_k;
    logic [SW-1:0]            term_sel;
    logic                     term_any;
    logic signed [AW-1:0]     addend;
    logic [MAXU-1:0]          pend;
    logic [MAXU-1:0]          dec_cur;
    logic [MAXU-1:0]          act_mask;
    logic                     dbl;
    logic [DW-1:0]            coef_rd;
    logic [MAXU-1:0][DW-1:0]  mf_all;
    logic [SW-1:0]            mf_ptr;
    logic [CW-1:0]            coef_ptr;

    mud_store #(.MAXU(MAXU), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (!busy),
        .restart    (accept),
        .mf_valid   (mf_valid),
        .mf_data    (mf_data),
        .coef_valid (coef_valid),
        .coef_data  (coef_data),
        .rd_row     (row_k),
        .rd_col     (term_sel),
        .coef_rd    (coef_rd),
        .mf_all     (mf_all),
        .mf_ptr     (mf_ptr),
        .coef_ptr   (coef_ptr)
    );

    mud_term #(.MAXU(MAXU), .DW(DW), .AW(AW)) u_term (
        .pend    (pend),
        .dec_cur (dec_cur),
        .coef    (coef_rd),
        .dbl     (dbl),
        .any     (term_any),
        .sel     (term_sel),
        .addend  (addend)
    );

    mud_ctrl #(.MAXU(MAXU), .DW(DW), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .num_users (num_users),
        .mf_all    (mf_all),
        .term_any  (term_any),
        .term_sel  (term_sel),
        .addend    (addend),
        .busy      (busy),
        .done      (done),
        .bits_out  (bits_out),
        .accept    (accept),
        .row_k     (row_k),
        .pend      (pend),
        .dec_cur   (dec_cur),
        .dbl       (dbl),
        .act_mask  (act_mask)
    );

endmodule

// File: rtl/mud_checker.sv
// Property checker for the canceller, bound into the top module.
// Observes ports and a few signals passed between the submodules.
module mud_checker #(
    parameter int MAXU = 8,
    parameter int DW   = 12
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           start,
    input logic                           busy,
    input logic                           done,
    input logic [MAXU-1:0]                bits_out,
    input logic [MAXU-1:0]                act_mask,
    input logic                           term_any,
    input logic [$clog2(MAXU)-1:0]        term_sel,
    input logic [$clog2(MAXU)-1:0]        row_k,
    input logic [$clog2(MAXU)-1:0]        mf_ptr,
    input logic [$clog2(MAXU*MAXU)-1:0]   coef_ptr,
    input logic [DW-1:0]                  mf_data
);
    localparam int LIMIT = 3 + 2 * (2 + MAXU * MAXU);

    int busy_run;
    logic unused_ok;
    assign unused_ok = ^mf_data;

    // Length of the current busy interval
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= 0;
        else        busy_run <= busy ? busy_run + 1 : 0;
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_start_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_idle_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((bits_out & ~act_mask) == '0));

    assert_no_diagonal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        term_any |-> (term_sel != row_k));

    assert_busy_writes_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mf_ptr) && $stable(coef_ptr)));

    assert_bounded_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= LIMIT);

endmodule

bind mai_canceller mud_checker #(.MAXU(MAXU), .DW(DW)) i_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .bits_out (bits_out),
    .act_mask (act_mask),
    .term_any (term_any),
    .term_sel (term_sel),
    .row_k    (row_k),
    .mf_ptr   (mf_ptr),
    .coef_ptr (coef_ptr),
    .mf_data  (mf_data)
);

// File: tb/test_mai_canceller.sv
// Self-checking bench: sweeps loads and user counts, comparing final
// decisions and run length with an arithmetic model of the requirements.
module test_mai_canceller;
    localparam int CLK_PERIOD = 10;
    localparam int NU = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  num_users = '0;
    logic        mf_valid = 1'b0;
    logic [11:0] mf_data = '0;
    logic        coef_valid = 1'b0;
    logic [11:0] coef_data = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        done;
    logic [7:0]  bits_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int unsigned seed = 32'h1234_5678;
    int ry[NU];
    int rr[NU][NU];

    always #(CLK_PERIOD/2) clk = ~clk;

    mai_canceller i_mai_canceller (
        .clk(clk), .rst_n(rst_n), .num_users(num_users),
        .mf_valid(mf_valid), .mf_data(mf_data),
        .coef_valid(coef_valid), .coef_data(coef_data),
        .start(start), .busy(busy), .done(done), .bits_out(bits_out)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd(input int lo, input int hi);
        seed = seed * 32'd1103515245 + 32'd12345;
        return lo + int'((seed >> 8) % unsigned'(hi - lo + 1));
    endfunction

    function automatic int sat12(input int v);
        if (v > 2047)  return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    // Reference model (R2, R3, R4, R5, R6, R7, R8)
    task automatic model(input int n, output logic [7:0] bits, output int cyc);
        int na; int acc; int nzc;
        int z[NU]; int dold[NU]; int dcur[NU]; int dnew[NU];
        na = (n > NU) ? NU : n;
        bits = '0;
        cyc = 3;
        for (int k = 0; k < NU; k++) begin
            z[k] = ry[k]; dcur[k] = (ry[k] >= 0) ? 1 : -1; dold[k] = 0; dnew[k] = 0;
        end
        for (int s = 0; s < 2; s++) begin
            nzc = 0;
            for (int j = 0; j < na; j++) if (dcur[j] != dold[j]) nzc++;
            if (nzc == 0) begin
                cyc++;
                for (int j = 0; j < NU; j++) dold[j] = dcur[j];
            end else begin
                cyc += 2;
                for (int k = 0; k < na; k++) begin
                    acc = z[k];
                    for (int j = 0; j < na; j++) begin
                        if (j != k && dcur[j] != dold[j]) begin
                            acc -= rr[k][j] * (dcur[j] - dold[j]);
                            cyc++;
                        end
                    end
                    cyc++;
                    z[k] = sat12(acc);
                    dnew[k] = (z[k] >= 0) ? 1 : -1;
                end
                for (int j = 0; j < NU; j++) begin
                    dold[j] = dcur[j]; dcur[j] = dnew[j];
                end
            end
        end
        for (int k = 0; k < na; k++) bits[k] = (dcur[k] > 0);
    endtask

    // Sequential load of samples then matrix (R1)
    task automatic load_all();
        @(negedge clk);
        for (int u = 0; u < NU; u++) begin
            mf_valid = 1'b1; mf_data = 12'(ry[u]);
            @(negedge clk);
        end
        mf_valid = 1'b0;
        for (int r = 0; r < NU; r++) begin
            for (int c = 0; c < NU; c++) begin
                coef_valid = 1'b1; coef_data = 12'(rr[r][c]);
                @(negedge clk);
            end
        end
        coef_valid = 1'b0;
    endtask

    task automatic run(input int n, input bit noise, input string tag);
        logic [7:0] eb; int ec; int cyc; bit seen; logic [7:0] held;
        model(n, eb, ec);
        @(negedge clk);
        num_users = 4'(n);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cyc = 1;
        if (noise) begin
            coef_valid = 1'b1; coef_data = 12'h7FF;
            mf_valid = 1'b1; mf_data = 12'h800;
            start = 1'b1;
        end
        seen = 1'b0;
        while (!seen && cyc < 3000) begin
            @(posedge clk); #1;
            cyc++;
            if (done) seen = 1'b1;
        end
        coef_valid = 1'b0; mf_valid = 1'b0; start = 1'b0;
        check(seen, "R9", {tag, " done pulse seen"}, int'(seen), 1);
        check(bits_out == eb, "R3", {tag, " final decisions"}, int'(bits_out), int'(eb));
        check(cyc == ec, "R6", {tag, " run length"}, cyc, ec);
        held = bits_out;
        @(posedge clk); #1;
        check(!done && !busy && bits_out == held, "R9", {tag, " pulse ends, bits held"},
              int'(done), 0);
    endtask

    initial begin
        logic [7:0] first;
        for (int k = 0; k < NU; k++) begin
            ry[k] = 0;
            for (int j = 0; j < NU; j++) rr[k][j] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        check(!busy && !done && bits_out == '0, "R9", "reset state", int'(bits_out), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: zero samples decide +1; zero matrix leaves stage two unchanged (R7)
        load_all();
        run(8, 1'b0, "R2 zero samples");

        // R7: converged after stage one, single-cycle second stage
        for (int k = 0; k < NU; k++) ry[k] = (k % 2 == 0) ? 500 : -700;
        load_all();
        run(8, 1'b0, "R7 zero matrix");

        // R4: large diagonal must not matter
        for (int k = 0; k < NU; k++) begin
            ry[k] = 40 * (k - 3);
            for (int j = 0; j < NU; j++) rr[k][j] = (j == k) ? 2047 : 15 * (j - k);
        end
        load_all();
        run(6, 1'b0, "R4 diagonal");

        // R5: saturated statistic decides stage-two flip
        for (int k = 0; k < NU; k++) begin
            ry[k] = 2047;
            for (int j = 0; j < NU; j++) rr[k][j] = 0;
        end
        ry[0] = 100; ry[1] = 10;
        rr[0][1] = 2047; rr[0][2] = 2047; rr[0][3] = 2047;
        rr[1][0] = 20;
        load_all();
        run(4, 1'b0, "R5 saturation");
        check(bits_out[0] == 1'b1, "R5", "clamped user 0 flips back", int'(bits_out[0]), 1);

        // R8: count above limit and idle users masked
        run(13, 1'b0, "R8 count clamp");
        run(2, 1'b0, "R8 two users");

        // R1: strobes and start during busy are ignored; rerun reproduces
        for (int k = 0; k < NU; k++) begin
            ry[k] = rnd(-2048, 2047);
            for (int j = 0; j < NU; j++) rr[k][j] = rnd(-600, 600);
        end
        load_all();
        run(8, 1'b1, "R1 noisy run");
        first = bits_out;
        run(8, 1'b0, "R1 rerun");
        check(bits_out == first, "R1", "storage untouched by busy writes",
              int'(bits_out), int'(first));

        // R3 exhaustive: four users, four sample levels each
        for (int k = 0; k < NU; k++)
            for (int j = 0; j < NU; j++)
                rr[k][j] = (j == k) ? 0 : (((k * 3 + j * 5) % 7) - 3) * 90;
        for (int p = 0; p < 256; p++) begin
            for (int u = 0; u < 4; u++) begin
                case ((p >> (2 * u)) & 3)
                    0: ry[u] = -300;
                    1: ry[u] = -1;
                    2: ry[u] = 0;
                    default: ry[u] = 250;
                endcase
            end
            for (int u = 4; u < NU; u++) ry[u] = 1000;
            load_all();
            run(4, 1'b0, "R3 sweep");
        end

        // R8/R6 random loads over every count
        for (int n = 0; n <= 10; n++) begin
            for (int t = 0; t < 10; t++) begin
                for (int k = 0; k < NU; k++) begin
                    ry[k] = rnd(-2048, 2047);
                    for (int j = 0; j < NU; j++)
                        rr[k][j] = (t < 5) ? rnd(-2048, 2047) : rnd(-200, 200);
                end
                load_all();
                run(n, 1'b0, "R8 random");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule